// File: doc/BRIEF.md
# Black-Level Clamp Loop and Blanked Output Pipeline

This block is the digital tail of a 14-bit image sample path. Each cycle it takes one converter code. While the optical-black window is active, it compares that code with a programmable black target and nudges a signed offset-correction word. The word feeds an external correction DAC. The step is a filtered fraction of the error, so the loop settles slowly and rejects pixel noise. The correction register holds its value outside the window, and also whenever software turns the loop off. In that case the clamp level register acts only as a programmed offset for the analog side.

In parallel, every sample runs through a fixed delay line and appears at the data output as a straight-binary code. The preblanking input zeroes a sample as it enters the delay line, so the zeros leave the block aligned with the samples they replace. Either clamp window (optical-black or input clamp) overrides preblanking. The active level of all three window inputs is programmable. The output can be launched on the rising or the falling clock edge. A control bit releases the pad drivers through a separate enable output.

Top module: `black_clamp_out`

## Requirements
- R1: While `rst_n` is low, `dout_o` and `corr_o` are zero. `dout_en_o` follows the inverse of `hiz_i`.
- R2: A sample presented on `smp_i` before rising edge k appears unchanged on `dout_o` after rising edge k+8, which is 9 cycles of latency. This holds when neither preblanking nor a clamp window is asserted.
- R3: The black target is 4 times `lvl_i`, giving 0 to 1020 in steps of 4. On each cycle in which the optical-black window is active and the loop is enabled, `corr_o` becomes the saturated sum of its old value and (target − sample) shifted right arithmetically by `FILT_SHIFT` (3 by default). That is floor((target − sample)/8).
- R4: `corr_o` saturates at 2047 and −2048 (for `CORR_W` = 12) and never wraps.
- R5: Outside the optical-black window, `corr_o` keeps its value whatever the sample is.
- R6: With `loop_off_i` high, `corr_o` keeps its value even inside the optical-black window. Data still flows through the pipeline.
- R7: A sample taken while preblanking is active leaves the block as code 0, with the same 9-cycle latency.
- R8: When the optical-black window or the input-clamp window is active, preblanking has no effect: the sample passes unchanged.
- R9: `win_pol_i` = 1 makes `obwin_i`, `dkwin_i` and `blank_i` active high. `win_pol_i` = 0 makes them active low.
- R10: With `fall_edge_i` high, `dout_o` updates on the falling clock edge, half a cycle after the rising-edge timing. Just after a rising edge it still shows the previous code.
- R11: `dout_en_o` is low while `hiz_i` is high and high otherwise. This releases the output drivers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_i | input | 14 | Converter sample, straight binary |
| obwin_i | input | 1 | Optical-black clamp window (level per `win_pol_i`) |
| dkwin_i | input | 1 | Input-clamp window (level per `win_pol_i`) |
| blank_i | input | 1 | Preblanking request (level per `win_pol_i`) |
| win_pol_i | input | 1 | 1 = window and blank inputs active high, 0 = active low |
| fall_edge_i | input | 1 | 1 = launch output data on falling edge |
| hiz_i | input | 1 | 1 = place data outputs in high impedance |
| lvl_i | input | 8 | Black clamp level code; target is 4 × code |
| loop_off_i | input | 1 | 1 = freeze the black-level loop |
| dout_o | output | 14 | Delayed, possibly blanked sample |
| dout_en_o | output | 1 | Output driver enable |
| corr_o | output | 12 | Signed offset-correction word for the DAC |

## Verification
Preblanking and a clamp window can be asserted in the same cycle. The bench provokes this by raising `blank_i` across stretches where first the optical-black window, then the input-clamp window, is also active. The bench judges the result by the data emerging 9 cycles later, which must carry the original codes and not zero. During the optical-black overlap it also checks that the correction word keeps integrating each cycle as the bench's own floor-division model predicts. The same overlap is repeated with active-low window polarity.

// File: rtl/bco_pkg.sv
package bco_pkg;

  typedef struct packed {
    logic ob;
    logic dk;
    logic blank;
  } win_act_t;

  function automatic int black_target(input int lvl_code);
    return lvl_code * 4;
  endfunction

  function automatic int filt_err(input int target, input int code, input int shift);
    int diff;
    diff = target - code;
    return diff >>> shift;
  endfunction

  function automatic int sat_sum(input int a, input int b, input int lo, input int hi);
    int s;
    s = a + b;
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    return s;
  endfunction

endpackage

// File: rtl/bco_win_decode.sv
module bco_win_decode
  import bco_pkg::*;
(
  input  logic     pol_i,
  input  logic     ob_raw_i,
  input  logic     dk_raw_i,
  input  logic     bl_raw_i,
  output win_act_t act_o,
  output logic     blank_eff_o
);
  always_comb begin
    act_o.ob    = (ob_raw_i == pol_i);
    act_o.dk    = (dk_raw_i == pol_i);
    act_o.blank = (bl_raw_i == pol_i);
    blank_eff_o = act_o.blank & ~act_o.ob & ~act_o.dk;
  end
endmodule

// File: rtl/bco_clamp_loop.sv
module bco_clamp_loop
  import bco_pkg::*;
#(
  parameter int SMP_W  = 14,
  parameter int LVL_W  = 8,
  parameter int CORR_W = 12,
  parameter int SHIFT  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     upd_i,
  input  logic [SMP_W-1:0]         smp_i,
  input  logic [LVL_W-1:0]         lvl_i,
  output logic signed [CORR_W-1:0] corr_o
);
  localparam int CMAX = (2 ** (CORR_W - 1)) - 1;
  localparam int CMIN = -(2 ** (CORR_W - 1));

  logic signed [CORR_W-1:0] corr_q;
  int                       nxt;

  always_comb begin
    nxt = sat_sum(int'(corr_q),
                  filt_err(black_target(int'(lvl_i)), int'(smp_i), SHIFT),
                  CMIN, CMAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     corr_q <= '0;
    else if (upd_i) corr_q <= CORR_W'(nxt);
  end

  assign corr_o = corr_q;
endmodule

// File: rtl/bco_delay_line.sv
module bco_delay_line #(
  parameter int W     = 14,
  parameter int DEPTH = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         zero_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] stage0_o,
  output logic [W-1:0] dout_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_st
    logic [W-1:0] q;
    if (g == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (zero_i) q <= '0;
        else             q <= din_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= g_st[g-1].q;
      end
    end
  end

  assign stage0_o = g_st[0].q;
  assign dout_o   = g_st[DEPTH-1].q;
endmodule

// File: rtl/bco_out_stage.sv
module bco_out_stage #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_i,
  input  logic         fall_i,
  input  logic         hiz_i,
  output logic [W-1:0] dout_o,
  output logic         oe_o
);
  logic [W-1:0] neg_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= '0;
    else        neg_q <= din_i;
  end

  assign dout_o = fall_i ? neg_q : din_i;
  assign oe_o   = ~hiz_i;
endmodule

// File: rtl/black_clamp_out.sv
module black_clamp_out
  import bco_pkg::*;
#(
  parameter int SMP_W      = 14,
  parameter int LVL_W      = 8,
  parameter int CORR_W     = 12,
  parameter int FILT_SHIFT = 3,
  parameter int LATENCY    = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [SMP_W-1:0]         smp_i,
  input  logic                     obwin_i,
  input  logic                     dkwin_i,
  input  logic                     blank_i,
  input  logic                     win_pol_i,
  input  logic                     fall_edge_i,
  input  logic                     hiz_i,
  input  logic [LVL_W-1:0]         lvl_i,
  input  logic                     loop_off_i,
  output logic [SMP_W-1:0]         dout_o,
  output logic                     dout_en_o,
  output logic signed [CORR_W-1:0] corr_o
);
  win_act_t         win_act;
  logic             ob_act;
  logic             dk_act;
  logic             blank_eff;
  logic             loop_upd;
  logic [SMP_W-1:0] stage0;
  logic [SMP_W-1:0] pipe_out;

  bco_win_decode u_win (
    .pol_i       (win_pol_i),
    .ob_raw_i    (obwin_i),
    .dk_raw_i    (dkwin_i),
    .bl_raw_i    (blank_i),
    .act_o       (win_act),
    .blank_eff_o (blank_eff)
  );

  assign ob_act   = win_act.ob;
  assign dk_act   = win_act.dk;
  assign loop_upd = ob_act & ~loop_off_i;

  bco_clamp_loop #(
    .SMP_W (SMP_W), .LVL_W (LVL_W), .CORR_W (CORR_W), .SHIFT (FILT_SHIFT)
  ) u_loop (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_i  (loop_upd),
    .smp_i  (smp_i),
    .lvl_i  (lvl_i),
    .corr_o (corr_o)
  );

  bco_delay_line #(.W (SMP_W), .DEPTH (LATENCY)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .zero_i   (blank_eff),
    .din_i    (smp_i),
    .stage0_o (stage0),
    .dout_o   (pipe_out)
  );

  bco_out_stage #(.W (SMP_W)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .din_i  (pipe_out),
    .fall_i (fall_edge_i),
    .hiz_i  (hiz_i),
    .dout_o (dout_o),
    .oe_o   (dout_en_o)
  );
endmodule

// File: rtl/bco_checker.sv
module bco_checker #(
  parameter int SMP_W  = 14,
  parameter int LVL_W  = 8,
  parameter int CORR_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     ob_act,
  input logic                     dk_act,
  input logic                     blank_eff,
  input logic                     loop_upd,
  input logic                     loop_off_i,
  input logic [SMP_W-1:0]         smp_i,
  input logic [LVL_W-1:0]         lvl_i,
  input logic [SMP_W-1:0]         stage0,
  input logic signed [CORR_W-1:0] corr_o
);
  AST_BLANK_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (ob_act || dk_act) |-> !blank_eff); // R8

  AST_STAGE0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    blank_eff |=> (stage0 == '0)); // R7

  AST_CORR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_upd |=> $stable(corr_o)); // R5

  AST_LOOP_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    loop_off_i |=> $stable(corr_o)); // R6

  AST_CORR_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_upd && (int'(smp_i) < 4 * int'(lvl_i))) |=> (corr_o >= $past(corr_o))); // R3
endmodule

bind black_clamp_out bco_checker #(
  .SMP_W (SMP_W), .LVL_W (LVL_W), .CORR_W (CORR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ob_act     (ob_act),
  .dk_act     (dk_act),
  .blank_eff  (blank_eff),
  .loop_upd   (loop_upd),
  .loop_off_i (loop_off_i),
  .smp_i      (smp_i),
  .lvl_i      (lvl_i),
  .stage0     (stage0),
  .corr_o     (corr_o)
);

// File: tb/black_clamp_out_tb_top.sv
module black_clamp_out_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [13:0]       d_smp = '0;
  logic              d_ob = 1'b0, d_dk = 1'b0, d_bl = 1'b0;
  logic              d_pol = 1'b1, d_fall = 1'b0, d_tri = 1'b0, d_off = 1'b0;
  logic [7:0]        d_lvl = '0;
  logic [13:0]       dout;
  logic              dout_en;
  logic signed [11:0] corr;

  bit c_pol = 1'b1, c_fall = 1'b0, c_tri = 1'b0, c_off = 1'b0;
  int c_lvl = 0;
  int cur_tag = 2;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  int mdl_corr = 0;
  int dq[$];
  int dtag[$];
  int cq[$];
  int ctag[$];

  always #5 clk = ~clk;

  black_clamp_out dut_i (
    .clk (clk), .rst_n (rst_n), .smp_i (d_smp), .obwin_i (d_ob), .dkwin_i (d_dk),
    .blank_i (d_bl), .win_pol_i (d_pol), .fall_edge_i (d_fall), .hiz_i (d_tri),
    .lvl_i (d_lvl), .loop_off_i (d_off), .dout_o (dout), .dout_en_o (dout_en),
    .corr_o (corr)
  );

  function automatic string tg(input int n);
    case (n)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Model: black target is four times the level code; step is the floor of error/8.
  task automatic push_exp();
    bit ob, dk, bl;
    int e, st;
    ob = (d_ob == d_pol);
    dk = (d_dk == d_pol);
    bl = (d_bl == d_pol);
    dq.push_back((bl && !ob && !dk) ? 0 : int'(d_smp));
    dtag.push_back(cur_tag);
    if (ob && !d_off) begin
      e  = 4 * int'(d_lvl) - int'(d_smp);
      st = (e >= 0) ? e / 8 : -((-e + 7) / 8);
      mdl_corr = mdl_corr + st;
      if (mdl_corr > 2047)  mdl_corr = 2047;
      if (mdl_corr < -2048) mdl_corr = -2048;
    end
    cq.push_back(mdl_corr);
    ctag.push_back(cur_tag);
  endtask

  // Driver: arguments give logical activity, converted to raw levels by polarity.
  task automatic step(input int smp, input bit ob, input bit dk, input bit bl);
    @(negedge clk);
    d_pol  = c_pol;  d_fall = c_fall; d_tri = c_tri; d_off = c_off;
    d_lvl  = 8'(c_lvl);
    d_smp  = 14'(smp);
    d_ob   = c_pol ? ob : !ob;
    d_dk   = c_pol ? dk : !dk;
    d_bl   = c_pol ? bl : !bl;
    push_exp();
  endtask

  // Monitor: scoreboard pops at 8 ns after each rising edge.
  int  last_s = 0;
  bit  prev_fall = 1'b0;
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && d_fall && prev_fall)
        check("R10", "dout before falling edge", int'(dout), last_s);
      #6;
      if (rst_n) begin
        if (cq.size() > 1)
          check(tg(ctag.pop_front()), "corr", int'(corr), cq.pop_front());
        if (dq.size() > 9)
          check(tg(dtag.pop_front()), "dout", int'(dout), dq.pop_front());
        check("R11", "dout_en", int'(dout_en), int'(!d_tri));
      end
      last_s    = int'(dout);
      prev_fall = d_fall;
    end
  end

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state
    d_smp = 14'd1234;
    repeat (3) @(negedge clk);
    check("R1", "dout in reset", int'(dout), 0);
    check("R1", "corr in reset", int'(corr), 0);
    check("R1", "dout_en in reset", int'(dout_en), 1);
    d_smp = '0;
    rst_n = 1'b1;
    push_exp();

    // R2: plain data ramp
    cur_tag = 2;
    for (int i = 0; i < 20; i++) step(i * 811 + 7, 0, 0, 0);

    // R3: integrate toward target 256 from below, then from above
    c_lvl = 64;
    cur_tag = 3;
    for (int i = 0; i < 6; i++) step(100, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(300 + i, 1, 0, 0);

    // R5: outside window, corr holds
    cur_tag = 5;
    for (int i = 0; i < 5; i++) step(16000 - i, 0, 0, 0);

    // R6: loop disabled inside window
    c_off = 1'b1;
    cur_tag = 6;
    for (int i = 0; i < 5; i++) step(5 + i * 3, 1, 0, 0);
    c_off = 1'b0;

    // R7: preblanking zeroes aligned samples
    cur_tag = 7;
    for (int i = 0; i < 6; i++) step(2000 + i, 0, 0, 1);
    step(4321, 0, 0, 0);

    // R8: blank overlapped with optical-black window, then input-clamp window
    cur_tag = 8;
    for (int i = 0; i < 4; i++) step(500 + i, 1, 0, 1);
    for (int i = 0; i < 4; i++) step(900 + i, 0, 1, 1);
    step(77, 0, 0, 1);

    // R9: active-low polarity for windows and blanking
    c_pol = 1'b0;
    cur_tag = 9;
    for (int i = 0; i < 3; i++) step(3000 + i, 0, 0, 1);
    for (int i = 0; i < 3; i++) step(40 + i, 1, 0, 1);
    for (int i = 0; i < 3; i++) step(60 + i, 0, 1, 1);
    step(123, 0, 0, 0);
    c_pol = 1'b1;

    // R4: saturation high then low
    cur_tag = 4;
    c_lvl = 255;
    for (int i = 0; i < 20; i++) step(0, 1, 0, 0);
    c_lvl = 0;
    for (int i = 0; i < 4; i++) step(16383, 1, 0, 0);

    // R10: falling-edge launch
    c_fall = 1'b1;
    cur_tag = 10;
    for (int i = 0; i < 15; i++) step(i * 1001 + 3, 0, 0, 0);
    c_fall = 1'b0;

    // R11: high impedance request
    c_tri = 1'b1;
    cur_tag = 11;
    for (int i = 0; i < 5; i++) step(700 + i, 0, 0, 0);
    c_tri = 1'b0;

    cur_tag = 2;
    for (int i = 0; i < 12; i++) step(i, 0, 0, 0);
    @(posedge clk);
    #9;
    finish_run();
  end
endmodule